// File: doc/BRIEF.md
# Pipelined Asynchronous SRAM Controller

This block is a bus slave that turns single-cycle read and write commands into accesses on an external asynchronous static RAM whose access time is two system clock cycles. The master pulses a read or write strobe for one cycle with the word address (and write data). The slave registers everything it needs and reports progress on a 2-bit ready counter. The counter gives the number of cycles left until the read result is on the bus or the write is complete, and it rests at 0 when nothing is pending.

Every RAM-side signal comes from a register: address, write data, data-drive enable, active-low chip select and output enable. The active-low write strobe comes from a flip-flop clocked on the falling edge, so one write fits in two cycles. Read data from the RAM pins is captured in an input register. The slave supports two levels of read overlap. A new read may be issued while the counter shows 1 for a read in flight. The new address then goes to the RAM in the same edge that captures the previous word, so back-to-back reads deliver one word every two cycles with no extra address or data register. Writes do not overlap.

Top module: `sramPipeSlave`

## Requirements
- R1: While reset is held and after it, the ready counter is 0, chip select, output enable and write strobe are high (inactive) and the data-drive enable is low.
- R2: The static read overlap level output is 2 and the write overlap level output is 0.
- R3: A read issued with the counter at 0 puts its address on the RAM pins with chip select and output enable low in the next cycle. The counter then reads 2, 1, 0 in the following three cycles, and the word is on the read data port in the cycle the counter reaches 0.
- R4: A read issued while the counter is 1 for a read in flight is accepted. Its address reaches the pins in the next cycle, the counter shows 2 then 1 for it, and the previous result stays on the read data port through both of those cycles.
- R5: A write issued with the counter at 0 puts address and write data on the pins with the drive enable high and output enable high in the next cycle, with the counter at 1. The write strobe goes low at the falling edge of that cycle and high again at the falling edge of the next one. The counter is 0 in that next cycle, when a new command may be issued.
- R6: Commands not accepted have no effect: any command while the counter is 2, a write while the counter is nonzero, and a read in the cycle after a write. The pins, the counter and the RAM contents stay as they would without the command.
- R7: If read and write strobes are high in the same cycle, the command is a read and nothing is written.
- R8: Output enable is never low together with a low write strobe or a high drive enable. Chip select and output enable are high once the slave is idle.
- R9: The RAM is narrower than the bus. A write stores only the low RAM-width bits of the write data, and read results carry zeros in the upper bus bits.
- R10: While no new read result arrives, the read data port keeps the last result and an idle counter stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | ADDR_W | Word address, valid with a command strobe |
| busWrData | input | DATA_W | Write data, valid with the write strobe |
| busRd | input | 1 | One-cycle read command |
| busWr | input | 1 | One-cycle write command |
| busRdData | output | DATA_W | Registered read result, zero padded |
| busRdyCnt | output | 2 | Cycles left until the pending command completes |
| busRdLevel | output | 2 | Static read overlap level (2) |
| busWrLevel | output | 2 | Static write overlap level (0) |
| ramAddr | output | ADDR_W | Registered RAM address |
| ramWrData | output | SRAM_W | Registered RAM write data |
| ramRdData | input | SRAM_W | Data from the RAM pins |
| ramDriveEn | output | 1 | High while the controller drives the RAM data lines |
| ramCsN | output | 1 | Active-low chip select |
| ramOeN | output | 1 | Active-low output enable |
| ramWeN | output | 1 | Active-low write strobe, falling-edge registered |

## Verification
On every cycle the assertions check four things. Output enable never overlaps the write strobe or the data drive. The address holds while the write strobe is low, and the strobe is low for a single rising edge. The counter never shows 3 and steps from 2 to 1. The read result stays put while a read is in flight or the slave is idle. Only the bench scenarios, run against a RAM model that returns data 15 ns after its address and controls settle, can show the rest. That covers the sampling edge of each read, the overlapped read stream, and reads directly after writes and writes directly after reads. It also covers the rejection of commands at the wrong counter values and the contents left in the RAM afterwards.

// File: rtl/sramPipePkg.sv
`timescale 1ns/1ps
package sramPipePkg;

  localparam logic [1:0] RD_OVERLAP = 2'd2;
  localparam logic [1:0] WR_OVERLAP = 2'd0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_WR1  = 2'd3
  } ctlState_t;

  // strobes from the sequencer to the datapath registers
  typedef struct packed {
    logic loadAddr;
    logic loadWrData;
    logic captureRd;
    logic csOn;
    logic oeOn;
    logic driveOn;
    logic wrPhase;
  } dpStrobe_t;

  function automatic logic [1:0] cntFor(ctlState_t s);
    case (s)
      ST_RD1:  cntFor = 2'd2;
      ST_RD2:  cntFor = 2'd1;
      ST_WR1:  cntFor = 2'd1;
      default: cntFor = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sramPipeFsm.sv
`timescale 1ns/1ps
module sramPipeFsm
  import sramPipePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busRd,
  input  logic       busWr,
  output dpStrobe_t  strobe,
  output logic [1:0] rdyCnt
);

  ctlState_t state, nextState;
  logic acceptRd, acceptWr;
  logic [1:0] cntQ;

  // reads may overlap the data phase of a read; writes need an idle slave
  assign acceptRd = busRd && (state == ST_IDLE || state == ST_RD2);
  assign acceptWr = busWr && !busRd && (state == ST_IDLE);

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (acceptRd)      nextState = ST_RD1;
        else if (acceptWr) nextState = ST_WR1;
        else               nextState = ST_IDLE;
      end
      ST_RD1:  nextState = ST_RD2;
      ST_RD2:  nextState = acceptRd ? ST_RD1 : ST_IDLE;
      ST_WR1:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.loadAddr   = acceptRd || acceptWr;
    strobe.loadWrData = acceptWr;
    strobe.captureRd  = (state == ST_RD2);
    // chip select and drive are held through the cycle after a write
    strobe.csOn       = (nextState != ST_IDLE) || (state == ST_WR1);
    strobe.oeOn       = (nextState == ST_RD1) || (nextState == ST_RD2);
    strobe.driveOn    = (nextState == ST_WR1) || (state == ST_WR1);
    strobe.wrPhase    = (nextState == ST_WR1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cntQ  <= 2'd0;
    end else begin
      state <= nextState;
      cntQ  <= cntFor(nextState);
    end
  end

  assign rdyCnt = cntQ;

  a_r3_cnt_steps_down: assert property (@(posedge clk) disable iff (!rstN)
    (rdyCnt == 2'd2) |=> (rdyCnt == 2'd1));

  a_r6_cnt_never_three: assert property (@(posedge clk) disable iff (!rstN)
    rdyCnt != 2'd3);

endmodule

// File: rtl/sramPipeDatapath.sv
`timescale 1ns/1ps
module sramPipeDatapath
  import sramPipePkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int SRAM_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [SRAM_W-1:0] ramWrData,
  input  logic [SRAM_W-1:0] ramRdData,
  output logic              ramDriveEn,
  output logic              ramCsN,
  output logic              ramOeN,
  output logic              ramWeN
);

  localparam int PAD_W = DATA_W - SRAM_W;

  logic [ADDR_W-1:0] addrQ;
  logic [SRAM_W-1:0] wrDataQ;
  logic [SRAM_W-1:0] rdDataQ;
  logic csNQ, oeNQ, driveQ, wrPhaseQ, weNQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      wrDataQ  <= '0;
      rdDataQ  <= '0;
      csNQ     <= 1'b1;
      oeNQ     <= 1'b1;
      driveQ   <= 1'b0;
      wrPhaseQ <= 1'b0;
    end else begin
      if (strobe.loadAddr)   addrQ   <= busAddr;
      if (strobe.loadWrData) wrDataQ <= busWrData[SRAM_W-1:0];
      if (strobe.captureRd)  rdDataQ <= ramRdData;
      csNQ     <= !strobe.csOn;
      oeNQ     <= !strobe.oeOn;
      driveQ   <= strobe.driveOn;
      wrPhaseQ <= strobe.wrPhase;
    end
  end

  // falling-edge strobe: low from mid first write cycle to mid second
  always_ff @(negedge clk) begin
    if (!rstN) weNQ <= 1'b1;
    else       weNQ <= !wrPhaseQ;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign busRdData = {{PAD_W{1'b0}}, rdDataQ};
    end else begin : g_full
      assign busRdData = rdDataQ;
    end
  endgenerate

  assign ramAddr    = addrQ;
  assign ramWrData  = wrDataQ;
  assign ramDriveEn = driveQ;
  assign ramCsN     = csNQ;
  assign ramOeN     = oeNQ;
  assign ramWeN     = weNQ;

  a_r8_oe_not_with_drive: assert property (@(posedge clk) disable iff (!rstN)
    !(!ramOeN && ramDriveEn));

  a_r8_oe_not_with_we: assert property (@(posedge clk) disable iff (!rstN)
    !(!ramOeN && !ramWeN));

  a_r5_we_single_edge: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |=> ramWeN);

  a_r5_addr_held_in_write: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |=> $stable(ramAddr));

endmodule

// File: rtl/sramPipeSlave.sv
`timescale 1ns/1ps
module sramPipeSlave
  import sramPipePkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int SRAM_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output logic [DATA_W-1:0] busRdData,
  output logic [1:0]        busRdyCnt,
  output logic [1:0]        busRdLevel,
  output logic [1:0]        busWrLevel,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [SRAM_W-1:0] ramWrData,
  input  logic [SRAM_W-1:0] ramRdData,
  output logic              ramDriveEn,
  output logic              ramCsN,
  output logic              ramOeN,
  output logic              ramWeN
);

  dpStrobe_t strobe;

  assign busRdLevel = RD_OVERLAP;
  assign busWrLevel = WR_OVERLAP;

  sramPipeFsm uFsm (
    .clk    (clk),
    .rstN   (rstN),
    .busRd  (busRd),
    .busWr  (busWr),
    .strobe (strobe),
    .rdyCnt (busRdyCnt)
  );

  sramPipeDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SRAM_W (SRAM_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .ramAddr    (ramAddr),
    .ramWrData  (ramWrData),
    .ramRdData  (ramRdData),
    .ramDriveEn (ramDriveEn),
    .ramCsN     (ramCsN),
    .ramOeN     (ramOeN),
    .ramWeN     (ramWeN)
  );

  initial begin
    a_r9_width_order: assert (SRAM_W <= DATA_W);
  end

  a_r4_result_held_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    (busRdyCnt == 2'd2) |=> $stable(busRdData));

  a_r10_result_held_idle: assert property (@(posedge clk) disable iff (!rstN)
    (busRdyCnt == 2'd0) |=> $stable(busRdData));

endmodule

// File: tb/tb_sramPipeSlave.sv
`timescale 1ns/1ps
module tb_sramPipeSlave;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int SW = 16;
  localparam int MEMN = 1 << AW;
  localparam realtime ACCESS = 15.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWrData = '0;
  logic busRd = 1'b0;
  logic busWr = 1'b0;
  logic [DW-1:0] busRdData;
  logic [1:0] busRdyCnt, busRdLevel, busWrLevel;
  logic [AW-1:0] ramAddr;
  logic [SW-1:0] ramWrData, ramOut;
  logic ramDriveEn, ramCsN, ramOeN, ramWeN;

  int checks = 0;
  int errors = 0;
  int stamp = 0;

  logic [SW-1:0] modelMem [0:MEMN-1];
  logic [SW-1:0] refMem   [0:MEMN-1];

  always #4 clk = ~clk;

  sramPipeSlave #(.ADDR_W(AW), .DATA_W(DW), .SRAM_W(SW)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busRd(busRd), .busWr(busWr), .busRdData(busRdData), .busRdyCnt(busRdyCnt),
    .busRdLevel(busRdLevel), .busWrLevel(busWrLevel), .ramAddr(ramAddr),
    .ramWrData(ramWrData), .ramRdData(ramOut), .ramDriveEn(ramDriveEn),
    .ramCsN(ramCsN), .ramOeN(ramOeN), .ramWeN(ramWeN)
  );

  // behavioural RAM: data valid only ACCESS after address/controls settle
  always @(ramAddr or ramCsN or ramOeN) begin
    stamp = stamp + 1;
    ramOut = 'x;
    fork
      begin
        automatic int myStamp = stamp;
        #(ACCESS);
        if (myStamp == stamp && ramCsN == 1'b0 && ramOeN == 1'b0)
          ramOut = modelMem[ramAddr];
      end
    join_none
  end

  always @(posedge ramWeN) begin
    if (ramCsN == 1'b0 && ramDriveEn == 1'b1) modelMem[ramAddr] = ramWrData;
  end

  initial begin
    for (int i = 0; i < MEMN; i++) begin
      modelMem[i] = SW'(16'hA000 ^ (i * 37));
      refMem[i]   = SW'(16'hA000 ^ (i * 37));
    end
  end

  task automatic nextCycle();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expData(input logic [AW-1:0] a);
    return {{(DW-SW){1'b0}}, refMem[a]};
  endfunction

  // called at a cycle where the counter is 0; returns where it is 0 again
  task automatic doRead(input logic [AW-1:0] a);
    busRd = 1'b1; busAddr = a;
    nextCycle();
    busRd = 1'b0;
    chk("R3 cnt 2", busRdyCnt, 2);
    chk("R3 addr pins", ramAddr, a);
    chk("R3 cs/oe low", {ramCsN, ramOeN}, 2'b00);
    nextCycle();
    chk("R3 cnt 1", busRdyCnt, 1);
    nextCycle();
    chk("R3 cnt 0", busRdyCnt, 0);
    chk("R3/R9 read data", busRdData, expData(a));
  endtask

  // returns at the cycle after the write cycle, counter 0
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    busWr = 1'b1; busAddr = a; busWrData = d;
    nextCycle();
    busWr = 1'b0;
    refMem[a] = d[SW-1:0];
    chk("R5 cnt 1", busRdyCnt, 1);
    chk("R5 addr pins", ramAddr, a);
    chk("R9 write data low bits", ramWrData, d[SW-1:0]);
    chk("R5 drive/oe/cs/we", {ramDriveEn, ramOeN, ramCsN, ramWeN}, 4'b1100);
    nextCycle();
    chk("R5 cnt 0", busRdyCnt, 0);
    chk("R5 we released", ramWeN, 1);
  endtask

  task automatic testReset();
    chk("R1 cnt", busRdyCnt, 0);
    chk("R1 cs/oe/we", {ramCsN, ramOeN, ramWeN}, 3'b111);
    chk("R1 drive", ramDriveEn, 0);
    chk("R2 rd level", busRdLevel, 2);
    chk("R2 wr level", busWrLevel, 0);
  endtask

  task automatic testSingleRead();
    doRead(10'd5);
    nextCycle();
    chk("R10 cnt idle", busRdyCnt, 0);
    chk("R10 data held", busRdData, expData(10'd5));
    chk("R8 idle cs/oe", {ramCsN, ramOeN}, 2'b11);
  endtask

  task automatic testPipelined();
    logic [AW-1:0] seq [4];
    seq[0] = 10'd100; seq[1] = 10'd3; seq[2] = 10'd1023; seq[3] = 10'd512;
    busRd = 1'b1; busAddr = seq[0];
    nextCycle();
    busRd = 1'b0;
    chk("R3 cnt 2", busRdyCnt, 2);
    nextCycle();
    chk("R3 cnt 1", busRdyCnt, 1);
    for (int k = 1; k < 4; k++) begin
      busRd = 1'b1; busAddr = seq[k];
      nextCycle();
      busRd = 1'b0;
      chk("R4 cnt 2", busRdyCnt, 2);
      chk("R4 addr pins", ramAddr, seq[k]);
      chk("R4 oe low", ramOeN, 0);
      chk("R4 data first cycle", busRdData, expData(seq[k-1]));
      nextCycle();
      chk("R4 cnt 1", busRdyCnt, 1);
      chk("R4 data second cycle", busRdData, expData(seq[k-1]));
    end
    nextCycle();
    chk("R4 last cnt", busRdyCnt, 0);
    chk("R4 last data", busRdData, expData(seq[3]));
  endtask

  task automatic testWriteThenRead();
    doWrite(10'd77, 32'hDEAD_1234);
    doRead(10'd77);
    doWrite(10'd78, 32'hFFFF_0001);
    doRead(10'd78);
  endtask

  task automatic testReadThenWrite();
    doRead(10'd200);
    doWrite(10'd200, 32'h0000_BEEF);
    doRead(10'd200);
  endtask

  task automatic testIgnored();
    logic [DW-1:0] held;
    busRd = 1'b1; busAddr = 10'd40;
    nextCycle();
    busRd = 1'b1; busWr = 1'b1; busAddr = 10'd41; busWrData = 32'h5555;
    nextCycle();
    busRd = 1'b0; busWr = 1'b1; busAddr = 10'd42; busWrData = 32'h6666;
    chk("R6 cnt 1 after ignored", busRdyCnt, 1);
    chk("R6 addr kept", ramAddr, 10'd40);
    nextCycle();
    busWr = 1'b0;
    chk("R6 cnt 0", busRdyCnt, 0);
    chk("R6 no drive", ramDriveEn, 0);
    chk("R6 data", busRdData, expData(10'd40));
    nextCycle();
    chk("R6 no write strobe", {ramWeN, ramCsN}, 2'b11);
    doRead(10'd41);
    doRead(10'd42);
    held = busRdData;
    busWr = 1'b1; busAddr = 10'd300; busWrData = 32'h0000_4321;
    nextCycle();
    busWr = 1'b0; busRd = 1'b1; busAddr = 10'd301;
    refMem[300] = 16'h4321;
    nextCycle();
    busRd = 1'b0;
    chk("R6 read after write ignored oe", ramOeN, 1);
    chk("R6 read after write addr", ramAddr, 10'd300);
    nextCycle();
    chk("R6 cnt stays 0", busRdyCnt, 0);
    chk("R6 data untouched", busRdData, held);
    doRead(10'd300);
  endtask

  task automatic testBoth();
    busRd = 1'b1; busWr = 1'b1; busAddr = 10'd9; busWrData = 32'h0000_AAAA;
    nextCycle();
    busRd = 1'b0; busWr = 1'b0;
    chk("R7 read chosen cnt", busRdyCnt, 2);
    chk("R7 no drive", ramDriveEn, 0);
    nextCycle();
    nextCycle();
    chk("R7 old data", busRdData, expData(10'd9));
    doRead(10'd9);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    nextCycle();
    nextCycle();
    testReset();
    rstN = 1'b1;
    nextCycle();
    testReset();
    testSingleRead();
    testPipelined();
    testWriteThenRead();
    testReadThenWrite();
    testIgnored();
    testBoth();
    nextCycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule